// File: doc/BRIEF.md
# Single-Wire Bus Reset and Bit-Slot Timing Engine

This block is the timing core of a master for a single-wire, open-drain bus. The pad sits outside the block. The block asks for the line to be pulled low through `bus_pull_low_o` and samples the line level through `bus_level_i`. The host can start two operations. A bus reset holds the line low, then checks twice: once for a device answering with presence, and once for a line that stays low and never recovers. A bit slot writes one bit, and in the same slot it always reads one bit back. The bus level is sampled inside the slot, so a slot that sends a 1 also serves as a read slot.

All timing is counted in microseconds. A prescaler makes one microsecond tick every `CLK_PER_US` clock cycles. Every interval is a parameter given in microseconds. A slot can ask for an active high drive, used to supply parasitically powered devices. That drive starts at the end of the slot's low phase. It stays on until the host clears it, or until the next operation starts.

Byte assembly, device addressing and device search belong to the layer above this block.

Top module: `owm_slot_engine`

## Requirements
- R1: An accepted reset pulls the line low for exactly RST_LOW_US*CLK_PER_US cycles. The pull begins in the cycle after the accepting edge. After that time the line is released.
- R2: PRES_US microseconds after the release, the line is sampled. A high level sets `no_presence_o` to 1, and a low level sets it to 0.
- R3: RST_TAIL_US microseconds after the presence sample, the line is sampled again. A low level sets `stuck_low_o` to 1, and a high level sets it to 0. The done pulse for the reset comes at this same edge, (RST_LOW_US+PRES_US+RST_TAIL_US)*CLK_PER_US cycles after acceptance.
- R4: Every slot first pulls the line low for INIT_US microseconds. When the slot sends a 1, the line is released after that, so the total low time is INIT_US*CLK_PER_US cycles.
- R5: SAMPLE_US microseconds after the slot starts, the line is sampled. `rx_bit_o` becomes the sent bit AND the sampled level, so a low sample gives 0.
- R6: When the slot sends a 0, the line stays low until LOW_US microseconds after the slot starts, for a total of LOW_US*CLK_PER_US cycles.
- R7: A recovery gap of REC_US microseconds follows the low phase. The done pulse for the slot comes (LOW_US+REC_US)*CLK_PER_US cycles after acceptance.
- R8: `start_reset_i` and `start_slot_i` have no effect while `busy_o` is 1. The operation in progress keeps its timing and gives exactly one done pulse.
- R9: If both strobes arrive in the same idle cycle, the reset is performed and the slot request is dropped.
- R10: If `strong_pu_i` was 1 when a slot was accepted, `bus_drive_high_o` rises at the end of the low phase. It stays at 1 until `strong_pu_clr_i` is seen. A clear in the same cycle as the end of the low phase wins.
- R11: Acceptance of any operation drops `bus_drive_high_o` in the next cycle. `bus_drive_high_o` and `bus_pull_low_o` are never 1 together.
- R12: After reset the block is idle. All outputs are 0.
- R13: `done_o` is 1 for exactly one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_reset_i | input | 1 | Strobe: start a bus reset with presence check |
| start_slot_i | input | 1 | Strobe: start a bit slot |
| tx_bit_i | input | 1 | Bit sent in the slot, captured at acceptance |
| strong_pu_i | input | 1 | Request an active high drive after this slot, captured at acceptance |
| strong_pu_clr_i | input | 1 | Ends the active high drive |
| bus_level_i | input | 1 | Sampled level of the bus line (already synchronous) |
| bus_pull_low_o | output | 1 | Pull the line low |
| bus_drive_high_o | output | 1 | Drive the line actively high |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse when an operation ends |
| rx_bit_o | output | 1 | Bit read in the last slot |
| no_presence_o | output | 1 | No device answered the last reset |
| stuck_low_o | output | 1 | Line was still low at the end of the last reset |

## Verification
Two collisions are provoked on purpose, because in each one two actions compete in a single cycle. The first is both start strobes in the same idle cycle. It is judged by the length of the low pulse and by the time of the done pulse, which must match a reset and not a slot. The second is a start strobe that lands in the middle of a running reset or slot. It is judged by an unchanged low time and done time, and by exactly one done pulse. The slot sample point is checked at its boundary by a device that releases the line one cycle before the sampling edge, and by one that holds the line through it.

// File: rtl/owm_pkg.sv
package owm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_RST_WAIT,
        ST_RST_TAIL,
        ST_SLOT_INIT,
        ST_SLOT_HOLD,
        ST_SLOT_REC
    } owm_state_e;

    typedef struct packed {
        owm_state_e st;
        logic       txb;
        logic       spu_req;
        logic       spu;
        logic       rx;
        logic       nopres;
        logic       stuck;
        logic       done;
    } owm_regs_t;

endpackage

// File: rtl/owm_us_tick.sv
module owm_us_tick #(
    parameter int CLK_PER_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart_i || cnt_q == LAST) cnt_d = '0;
        else                            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == LAST);

    generate
        if (CLK_PER_US > 1) begin : g_gap
            assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (tick_o && !restart_i) |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/owm_us_count.sv
module owm_us_count #(
    parameter int UW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          inc_i,
    output logic [UW-1:0] us_o
);
    logic [UW-1:0] us_d, us_q;

    always_comb begin
        if (clear_i)    us_d = '0;
        else if (inc_i) us_d = us_q + 1'b1;
        else            us_d = us_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) us_q <= '0;
        else        us_q <= us_d;
    end

    assign us_o = us_q;
endmodule

// File: rtl/owm_slot_engine.sv
module owm_slot_engine
    import owm_pkg::*;
#(
    parameter int CLK_PER_US  = 50,
    parameter int RST_LOW_US  = 480,
    parameter int PRES_US     = 64,
    parameter int RST_TAIL_US = 416,
    parameter int INIT_US     = 2,
    parameter int SAMPLE_US   = 15,
    parameter int LOW_US      = 60,
    parameter int REC_US      = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_reset_i,
    input  logic start_slot_i,
    input  logic tx_bit_i,
    input  logic strong_pu_i,
    input  logic strong_pu_clr_i,
    input  logic bus_level_i,
    output logic bus_pull_low_o,
    output logic bus_drive_high_o,
    output logic busy_o,
    output logic done_o,
    output logic rx_bit_o,
    output logic no_presence_o,
    output logic stuck_low_o
);
    localparam int T_PRES   = RST_LOW_US + PRES_US;
    localparam int T_RSTEND = T_PRES + RST_TAIL_US;
    localparam int T_SLTEND = LOW_US + REC_US;
    localparam int T_MAX    = (T_RSTEND > T_SLTEND) ? T_RSTEND : T_SLTEND;
    localparam int UW       = $clog2(T_MAX + 1);

    localparam logic [UW-1:0] E_RST_LOW = UW'(RST_LOW_US - 1);
    localparam logic [UW-1:0] E_PRES    = UW'(T_PRES - 1);
    localparam logic [UW-1:0] E_RSTEND  = UW'(T_RSTEND - 1);
    localparam logic [UW-1:0] E_INIT    = UW'(INIT_US - 1);
    localparam logic [UW-1:0] E_SAMPLE  = UW'(SAMPLE_US - 1);
    localparam logic [UW-1:0] E_LOW     = UW'(LOW_US - 1);
    localparam logic [UW-1:0] E_SLTEND  = UW'(T_SLTEND - 1);

    generate
        if (INIT_US < 1 || SAMPLE_US <= INIT_US || LOW_US <= SAMPLE_US ||
            REC_US < 1 || PRES_US < 1 || RST_TAIL_US < 1 || RST_LOW_US < 1)
        begin : g_bad_timing
            $error("owm_slot_engine: interval parameters out of order");
        end
    endgenerate

    owm_regs_t r_d, r_q;
    logic          tick;
    logic [UW-1:0] us;
    logic          accept_rst, accept_slot, accept;

    assign accept_rst  = (r_q.st == ST_IDLE) && start_reset_i;
    assign accept_slot = (r_q.st == ST_IDLE) && start_slot_i && !start_reset_i;
    assign accept      = accept_rst || accept_slot;

    owm_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (accept),
        .tick_o    (tick)
    );

    owm_us_count #(.UW(UW)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .inc_i   (tick && (r_q.st != ST_IDLE)),
        .us_o    (us)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept_rst) begin
                    r_d.st     = ST_RST_LOW;
                    r_d.spu    = 1'b0;
                    r_d.nopres = 1'b0;
                    r_d.stuck  = 1'b0;
                end else if (accept_slot) begin
                    r_d.st      = ST_SLOT_INIT;
                    r_d.txb     = tx_bit_i;
                    r_d.spu_req = strong_pu_i;
                    r_d.spu     = 1'b0;
                end
            end
            ST_RST_LOW: begin
                if (tick && us == E_RST_LOW) r_d.st = ST_RST_WAIT;
            end
            ST_RST_WAIT: begin
                if (tick && us == E_PRES) begin
                    r_d.nopres = bus_level_i;
                    r_d.st     = ST_RST_TAIL;
                end
            end
            ST_RST_TAIL: begin
                if (tick && us == E_RSTEND) begin
                    r_d.stuck = !bus_level_i;
                    r_d.st    = ST_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            ST_SLOT_INIT: begin
                if (tick && us == E_INIT) r_d.st = ST_SLOT_HOLD;
            end
            ST_SLOT_HOLD: begin
                if (tick && us == E_SAMPLE) r_d.rx = r_q.txb & bus_level_i;
                if (tick && us == E_LOW) begin
                    r_d.st  = ST_SLOT_REC;
                    r_d.spu = r_q.spu_req;
                end
            end
            ST_SLOT_REC: begin
                if (tick && us == E_SLTEND) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (strong_pu_clr_i) r_d.spu = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: 1'b0};
        else        r_q <= r_d;
    end

    assign busy_o           = (r_q.st != ST_IDLE);
    assign bus_pull_low_o   = (r_q.st == ST_RST_LOW) || (r_q.st == ST_SLOT_INIT) ||
                              ((r_q.st == ST_SLOT_HOLD) && !r_q.txb);
    assign bus_drive_high_o = r_q.spu;
    assign done_o           = r_q.done;
    assign rx_bit_o         = r_q.rx;
    assign no_presence_o    = r_q.nopres;
    assign stuck_low_o      = r_q.stuck;

    assert_drive_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_pull_low_o && bus_drive_high_o));
    assert_spu_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !bus_drive_high_o);
    assert_rst_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE && r_q.st != ST_RST_LOW) |=> (r_q.st != ST_RST_LOW));
    assert_slot_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE && r_q.st != ST_SLOT_INIT) |=> (r_q.st != ST_SLOT_INIT));
    assert_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_reset_i && start_slot_i) |=> (r_q.st == ST_RST_LOW));
    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_low_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_pull_low_o |-> busy_o);
    assert_spu_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        strong_pu_clr_i |=> !bus_drive_high_o);
endmodule

// File: tb/owm_slot_engine_tb_top.sv
module owm_slot_engine_tb_top;
    localparam int C    = 2;
    localparam int RLOW = 480, PRES = 64, TAIL = 416;
    localparam int INIT = 2, SAMP = 15, LOW = 60, REC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_reset_i = 0, start_slot_i = 0, tx_bit_i = 0;
    logic strong_pu_i = 0, strong_pu_clr_i = 0;
    logic slave_low = 0;
    logic bus_level_i;
    logic bus_pull_low_o, bus_drive_high_o, busy_o, done_o;
    logic rx_bit_o, no_presence_o, stuck_low_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign bus_level_i = !(bus_pull_low_o || slave_low);

    owm_slot_engine #(
        .CLK_PER_US(C), .RST_LOW_US(RLOW), .PRES_US(PRES), .RST_TAIL_US(TAIL),
        .INIT_US(INIT), .SAMPLE_US(SAMP), .LOW_US(LOW), .REC_US(REC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .start_reset_i(start_reset_i), .start_slot_i(start_slot_i),
        .tx_bit_i(tx_bit_i), .strong_pu_i(strong_pu_i),
        .strong_pu_clr_i(strong_pu_clr_i), .bus_level_i(bus_level_i),
        .bus_pull_low_o(bus_pull_low_o), .bus_drive_high_o(bus_drive_high_o),
        .busy_o(busy_o), .done_o(done_o), .rx_bit_o(rx_bit_o),
        .no_presence_o(no_presence_o), .stuck_low_o(stuck_low_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_rx(input int tx, input int hold);
        return (tx != 0 && hold < SAMP * C) ? 1 : 0;
    endfunction

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Strobe at a negedge; returns at the negedge after the accepting edge.
    task automatic strobe(input bit r, input bit s, input bit tx, input bit spu);
        @(negedge clk);
        start_reset_i = r; start_slot_i = s; tx_bit_i = tx; strong_pu_i = spu;
        @(posedge clk);
        @(negedge clk);
        start_reset_i = 0; start_slot_i = 0;
    endtask

    // mode 0: no device, 1: presence pulse, 2: line held low
    task automatic run_reset(input int mode, input bit also_slot, input int inject_at);
        int low_cnt = 0, done_k = -1, dones = 0;
        if (mode == 2) slave_low = 1;
        strobe(1, also_slot, 0, 0);
        check("R11 high drive off after accept", bus_drive_high_o, 0);
        for (int k = 0; k < 3000; k++) begin
            if (bus_pull_low_o) low_cnt++;
            if (done_o) begin dones++; if (done_k < 0) done_k = k; end
            if (done_k >= 0 && k > done_k + 2) break;
            if (mode == 1) slave_low = (k + 1 >= 1000 && k + 1 < 1200);
            start_slot_i  = (k == inject_at);
            start_reset_i = (k == inject_at);
            @(negedge clk);
        end
        start_slot_i = 0; start_reset_i = 0; slave_low = 0;
        check("R1 reset low time", low_cnt, RLOW * C);
        check("R3 reset done time", done_k, (RLOW + PRES + TAIL) * C);
        check("R13 one done pulse", dones, 1);
        check("R2 presence result", no_presence_o, (mode == 0) ? 1 : 0);
        check("R3 stuck-low result", stuck_low_o, (mode == 2) ? 1 : 0);
    endtask

    task automatic run_slot(input bit tx, input int hold, input bit spu,
                            input int inject_at, input bit clr_at_end);
        int low_cnt = 0, done_k = -1, dones = 0, hi_rec = 0;
        strobe(0, 1, tx, spu);
        check("R11 high drive off after accept", bus_drive_high_o, 0);
        for (int k = 0; k < 400; k++) begin
            if (bus_pull_low_o) low_cnt++;
            if (k == LOW * C + 1) hi_rec = bus_drive_high_o;
            if (done_o) begin dones++; if (done_k < 0) done_k = k; end
            if (done_k >= 0 && k > done_k + 1) break;
            slave_low = (k + 1 <= hold);
            start_reset_i = (k == inject_at);
            strong_pu_clr_i = clr_at_end && (k == LOW * C - 1);
            @(negedge clk);
        end
        start_reset_i = 0; slave_low = 0; strong_pu_clr_i = 0;
        check("R4 R6 slot low time", low_cnt, tx ? INIT * C : LOW * C);
        check("R7 slot done time", done_k, (LOW + REC) * C);
        check("R13 one done pulse", dones, 1);
        check("R5 returned bit", rx_bit_o, exp_rx(tx, hold));
        check("R10 high drive in recovery", hi_rec, (spu && !clr_at_end) ? 1 : 0);
        check("R10 high drive after done", bus_drive_high_o, (spu && !clr_at_end) ? 1 : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R12: outputs idle after reset
        check("R12 busy", busy_o, 0);
        check("R12 pull low", bus_pull_low_o, 0);
        check("R12 drive high", bus_drive_high_o, 0);
        check("R12 done", done_o, 0);
        check("R12 status", {rx_bit_o, no_presence_o, stuck_low_o}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);

        run_reset(1, 0, -1);          // device answers
        run_reset(0, 0, -1);          // R2 nobody present
        run_reset(2, 0, -1);          // R3 line stuck low
        run_reset(1, 1, -1);          // R9 both strobes together
        run_reset(1, 0, 300);         // R8 strobes during reset

        // R5 sample boundary: release one cycle before / hold through sample edge
        run_slot(1, SAMP * C - 1, 0, -1, 0);
        run_slot(1, SAMP * C, 0, -1, 0);
        run_slot(0, 0, 0, 50, 0);     // R8 strobe during slot

        // R10 high drive held until cleared
        run_slot(1, 0, 1, -1, 0);
        repeat (10) @(negedge clk);
        check("R10 high drive held", bus_drive_high_o, 1);
        strong_pu_clr_i = 1;
        @(negedge clk);
        strong_pu_clr_i = 0;
        check("R10 high drive cleared", bus_drive_high_o, 0);
        // R10 clear in same cycle as end of low phase wins
        run_slot(0, 0, 1, -1, 1);
        // R11 a new op drops a held high drive
        run_slot(1, 0, 1, -1, 0);
        run_slot(0, 0, 0, -1, 0);

        for (int i = 0; i < 30; i++) begin
            bit tx  = 1'($urandom % 2);
            bit sb  = 1'($urandom % 2);
            bit spu = 1'($urandom % 2);
            int hold = sb ? int'($urandom % (SAMP * C)) : SAMP * C + int'($urandom % 40);
            run_slot(tx, hold, spu, -1, 0);
            if (spu && ($urandom % 2)) begin
                strong_pu_clr_i = 1;
                @(negedge clk);
                strong_pu_clr_i = 0;
                check("R10 random clear", bus_drive_high_o, 0);
            end
        end
        run_reset(1, 0, -1);
        finish_run();
    end
endmodule